// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block steers a 32-bit core into and out of its exception handlers. The execution stage reports a 16-bit exception code, and a 5-bit request vector brings in maskable interrupts. The block holds the processor status word, the two saved program-counter and status pairs, and the exception cause register. On each entry it sends a one-cycle redirect with the handler address to the fetch logic. A return strobe brings back the saved program counter and status word from one of the two pairs.

Nesting has three depths. The first entry saves into the primary pair and vectors by cause code. An entry taken while the primary handler runs saves into the secondary pair and goes to one fixed address. An entry taken while the secondary handler runs is fatal: the block writes the cause, status word and program counter to low memory, then stops for good.

Entry takes two clock edges. The first edge latches the cause into a pending register, and the second edge performs the save and the redirect. A cause that arrives during the entry cycle is held and entered next.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, redirect_pc_o is 0xFFFFFFF0, ecr_o is 0x0000FFF0, psw_o is 0x00008000 (nesting-2 bit 15 set), and fatal_o, mem_wr_o, redirect_o and wake_o are 0.
- R2: An interrupt is taken only when no exception is pending or arriving and PSW bits 12 (disable), 14 (nesting-1) and 15 (nesting-2) are all 0. The highest set request bit L, searched from 4 down to 0, gives the code 0xFE00 | L<<4.
- R3: An entry with bits 14 and 15 both clear writes the code to ecr_o[15:0], the saved PC to eipc_o and the old PSW to eipsw_o. It sets bit 14 and redirects to 0xFFFF0000 | (code & 0xFFF0), except that 0xFFFFFF70 becomes 0xFFFFFF60.
- R4: An entry with bit 14 set and bit 15 clear writes the code to ecr_o[31:16], the saved PC to fepc_o and the old PSW to fepsw_o. It sets bit 15 and redirects to 0xFFFFFFD0.
- R5: An entry with bit 15 set asserts fatal_o for good and makes three writes on consecutive cycles: 0xFFFF0000|code to address 0, the PSW to address 4 and cur_pc_i to address 8. All later inputs are then ignored.
- R6: For an interrupt entry (code bits 15:8 equal 0xFE), PSW bits 19:16 take code bits 7:4. If halted_i is high, the saved PC is cur_pc_i+2 and wake_o pulses with the redirect.
- R7: Every non-fatal entry clears PSW bit 13, sets PSW bit 12 and pulses redirect_o for one cycle, two clock edges after the cause is presented.
- R8: A return strobe with no entry in progress redirects to fepc_o and loads psw_o from fepsw_o when bit 15 is set. Otherwise it uses eipc_o and eipsw_o.
- R9: Saved PCs have bit 0 cleared. Every PSW value that is stored or loaded is masked to 0x000FF3FF.
- R10: An exception presented on the clock edge that performs an entry is kept and entered on the next edge.
- R11: An exception and an interrupt presented on the same edge: the exception is taken and the interrupt is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 5 | Interrupt request lines, bit 4 highest |
| exc_valid_i | input | 1 | Exception reported this cycle |
| exc_code_i | input | 16 | Exception cause code |
| cur_pc_i | input | 32 | PC to save on entry |
| halted_i | input | 1 | Core is stopped waiting for an interrupt |
| reti_i | input | 1 | Return-from-handler strobe |
| psw_wr_i | input | 1 | Execution writes the PSW |
| psw_wr_data_i | input | 32 | PSW write value |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc_o | output | 32 | Redirect target / current PC |
| psw_o | output | 32 | Processor status word |
| eipc_o | output | 32 | Primary saved PC |
| eipsw_o | output | 32 | Primary saved PSW |
| fepc_o | output | 32 | Secondary saved PC |
| fepsw_o | output | 32 | Secondary saved PSW |
| ecr_o | output | 32 | Cause register, secondary code high, primary code low |
| wake_o | output | 1 | Interrupt entry woke a halted core |
| fatal_o | output | 1 | Permanent fatal stop |
| mem_wr_o | output | 1 | Fatal dump write strobe |
| mem_addr_o | output | 32 | Fatal dump address |
| mem_data_o | output | 32 | Fatal dump data |

## Verification
The bench uses the 0xFFFFFF70 cause to check the vector redirect. A design that skipped the redirect would vector to 0xFFFFFF70.

It presents a second cause on the entry edge. A design that lost this cause would never reach the secondary pair.

It raises interrupts while the disable or nesting bits are set, and presents an interrupt on the same edge as an exception. A design with the wrong gating or priority would take a second entry or record an interrupt code in the cause register.

It checks the +2 on the saved PC after a wake from halt, the choice of pair on return, and the three-write fatal dump. A design that froze too late or too early would show changed registers after the dump, or a missing or misaddressed write.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XW        = 32;
  localparam int unsigned CODE_W    = 16;
  localparam logic [XW-1:0] PSW_KEEP  = 32'h000F_F3FF;
  localparam logic [XW-1:0] PSW_RST   = 32'h0000_8000;
  localparam logic [XW-1:0] PC_RST    = 32'hFFFF_FFF0;
  localparam logic [XW-1:0] ECR_RST   = 32'h0000_FFF0;
  localparam logic [XW-1:0] VEC_SEC   = 32'hFFFF_FFD0;
  localparam logic [XW-1:0] VEC_ODD   = 32'hFFFF_FF70;
  localparam logic [XW-1:0] VEC_ALT   = 32'hFFFF_FF60;
  localparam logic [XW-1:0] DUMP_TAG  = 32'hFFFF_0000;
  localparam int unsigned B_NP = 15;
  localparam int unsigned B_EP = 14;
  localparam int unsigned B_AE = 13;
  localparam int unsigned B_ID = 12;
  localparam int unsigned B_IL = 16;
  localparam logic [7:0] IRQ_CLASS = 8'hFE;
  localparam int unsigned DUMP_WORDS = 3;

  function automatic logic [XW-1:0] f_primary_vec(input logic [CODE_W-1:0] code);
    logic [XW-1:0] v;
    v = {16'hFFFF, code[15:4], 4'h0};
    if (v == VEC_ODD) v = VEC_ALT;
    return v;
  endfunction

  function automatic logic [XW-1:0] f_save_pc(input logic [XW-1:0] pc, input logic bump);
    logic [XW-1:0] s;
    s = pc + (bump ? 32'd2 : 32'd0);
    s[0] = 1'b0;
    return s;
  endfunction

  function automatic logic f_is_irq(input logic [CODE_W-1:0] code);
    return code[15:8] == IRQ_CLASS;
  endfunction

  function automatic logic [CODE_W-1:0] f_irq_code(input logic [3:0] lvl);
    return {IRQ_CLASS, lvl, 4'h0};
  endfunction
endpackage

// File: rtl/exc_irq_pick.sv
module exc_irq_pick #(
  parameter int unsigned LEVELS = 5
) (
  input  logic [LEVELS-1:0] req_i,
  output logic              any_o,
  output logic [3:0]        level_o
);
  always_comb begin
    level_o = 4'd0;
    for (int i = 0; i < LEVELS; i++) begin
      if (req_i[i]) level_o = 4'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/exc_pend.sv
module exc_pend
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_ok_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic              consume_i,
  output logic              pend_v_o,
  output logic [CODE_W-1:0] pend_code_o,
  output logic              irq_take_o
);
  assign irq_take_o = irq_ok_i && !pend_v_o && !exc_valid_i && !freeze_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_o    <= 1'b0;
      pend_code_o <= '0;
    end else if (!freeze_i) begin
      if (exc_valid_i) begin
        pend_v_o    <= 1'b1;
        pend_code_o <= exc_code_i;
      end else if (consume_i) begin
        pend_v_o    <= 1'b0;
      end else if (irq_take_o) begin
        pend_v_o    <= 1'b1;
        pend_code_o <= irq_code_i;
      end
    end
  end

  // R11: an arriving exception always wins the pending slot over an interrupt
  a_r11_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_i && !freeze_i) |=> (pend_v_o && pend_code_o == $past(exc_code_i)));
endmodule

// File: rtl/exc_dump.sv
module exc_dump
  import exc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [XW-1:0] w0_i,
  input  logic [XW-1:0] w1_i,
  input  logic [XW-1:0] w2_i,
  output logic          wr_o,
  output logic [XW-1:0] addr_o,
  output logic [XW-1:0] data_o
);
  localparam int unsigned IW = $clog2(DUMP_WORDS);
  logic [XW-1:0] words_q [DUMP_WORDS];
  logic [IW-1:0] idx_q;
  logic          act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      for (int i = 0; i < DUMP_WORDS; i++) words_q[i] <= '0;
    end else if (start_i) begin
      act_q      <= 1'b1;
      idx_q      <= '0;
      words_q[0] <= w0_i;
      words_q[1] <= w1_i;
      words_q[2] <= w2_i;
    end else if (act_q) begin
      if (idx_q == IW'(DUMP_WORDS - 1)) act_q <= 1'b0;
      else idx_q <= idx_q + 1'b1;
    end
  end

  assign wr_o   = act_q;
  assign addr_o = XW'({idx_q, 2'b00});
  assign data_o = words_q[idx_q];

  // R5: dump addresses stay inside the three-word window
  a_r5_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (addr_o <= XW'(4 * (DUMP_WORDS - 1))));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned IRQ_LEVELS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IRQ_LEVELS-1:0] irq_req_i,
  input  logic                  exc_valid_i,
  input  logic [15:0]           exc_code_i,
  input  logic [31:0]           cur_pc_i,
  input  logic                  halted_i,
  input  logic                  reti_i,
  input  logic                  psw_wr_i,
  input  logic [31:0]           psw_wr_data_i,
  output logic                  redirect_o,
  output logic [31:0]           redirect_pc_o,
  output logic [31:0]           psw_o,
  output logic [31:0]           eipc_o,
  output logic [31:0]           eipsw_o,
  output logic [31:0]           fepc_o,
  output logic [31:0]           fepsw_o,
  output logic [31:0]           ecr_o,
  output logic                  wake_o,
  output logic                  fatal_o,
  output logic                  mem_wr_o,
  output logic [31:0]           mem_addr_o,
  output logic [31:0]           mem_data_o
);
  logic [XW-1:0] psw_q, rpc_q, eipc_q, eipsw_q, fepc_q, fepsw_q, ecr_q;
  logic          fatal_q, redir_q, wake_q;

  logic              irq_any, irq_ok, irq_take;
  logic [3:0]        irq_lvl;
  logic              pend_v;
  logic [CODE_W-1:0] pend_code;

  exc_irq_pick #(.LEVELS(IRQ_LEVELS)) u_pick (
    .req_i(irq_req_i), .any_o(irq_any), .level_o(irq_lvl)
  );

  assign irq_ok = irq_any && !psw_q[B_ID] && !psw_q[B_EP] && !psw_q[B_NP];

  // named entry events
  logic entry_evt, entry_first, entry_second, entry_fatal, restore_evt, is_irq, bump;
  assign entry_evt    = pend_v && !fatal_q;
  assign entry_fatal  = entry_evt && psw_q[B_NP];
  assign entry_second = entry_evt && !psw_q[B_NP] && psw_q[B_EP];
  assign entry_first  = entry_evt && !psw_q[B_NP] && !psw_q[B_EP];
  assign restore_evt  = reti_i && !fatal_q && !entry_evt;
  assign is_irq       = f_is_irq(pend_code);
  assign bump         = is_irq && halted_i;

  exc_pend u_pend (
    .clk(clk), .rst_n(rst_n), .freeze_i(fatal_q),
    .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
    .irq_ok_i(irq_ok), .irq_code_i(f_irq_code(irq_lvl)),
    .consume_i(entry_evt),
    .pend_v_o(pend_v), .pend_code_o(pend_code), .irq_take_o(irq_take)
  );

  exc_dump u_dump (
    .clk(clk), .rst_n(rst_n), .start_i(entry_fatal),
    .w0_i(DUMP_TAG | XW'(pend_code)), .w1_i(psw_q), .w2_i(cur_pc_i),
    .wr_o(mem_wr_o), .addr_o(mem_addr_o), .data_o(mem_data_o)
  );

  logic [XW-1:0] save_pc, psw_entry;
  assign save_pc = f_save_pc(cur_pc_i, bump);

  always_comb begin
    psw_entry = psw_q;
    if (entry_first)  psw_entry[B_EP] = 1'b1;
    if (entry_second) psw_entry[B_NP] = 1'b1;
    if (is_irq)       psw_entry[B_IL +: 4] = pend_code[7:4];
    psw_entry[B_AE] = 1'b0;
    psw_entry[B_ID] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q   <= PSW_RST;
      rpc_q   <= PC_RST;
      ecr_q   <= ECR_RST;
      eipc_q  <= '0;
      eipsw_q <= '0;
      fepc_q  <= '0;
      fepsw_q <= '0;
      fatal_q <= 1'b0;
      redir_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      redir_q <= 1'b0;
      wake_q  <= 1'b0;
      if (entry_fatal) begin
        fatal_q <= 1'b1;
      end else if (entry_second) begin
        ecr_q[31:16] <= pend_code;
        fepc_q       <= save_pc;
        fepsw_q      <= psw_q & PSW_KEEP;
        psw_q        <= psw_entry & PSW_KEEP;
        rpc_q        <= VEC_SEC;
        redir_q      <= 1'b1;
        wake_q       <= bump;
      end else if (entry_first) begin
        ecr_q[15:0]  <= pend_code;
        eipc_q       <= save_pc;
        eipsw_q      <= psw_q & PSW_KEEP;
        psw_q        <= psw_entry & PSW_KEEP;
        rpc_q        <= f_primary_vec(pend_code);
        redir_q      <= 1'b1;
        wake_q       <= bump;
      end else if (restore_evt) begin
        rpc_q   <= psw_q[B_NP] ? fepc_q : eipc_q;
        psw_q   <= (psw_q[B_NP] ? fepsw_q : eipsw_q) & PSW_KEEP;
        redir_q <= 1'b1;
      end else if (psw_wr_i && !fatal_q) begin
        psw_q <= psw_wr_data_i & PSW_KEEP;
      end
    end
  end

  assign redirect_o    = redir_q;
  assign redirect_pc_o = rpc_q;
  assign psw_o         = psw_q;
  assign eipc_o        = eipc_q;
  assign eipsw_o       = eipsw_q;
  assign fepc_o        = fepc_q;
  assign fepsw_o       = fepsw_q;
  assign ecr_o         = ecr_q;
  assign wake_o        = wake_q;
  assign fatal_o       = fatal_q;

  // R3: primary entry raises nesting-1 and vectors into the high page
  a_r3_first_level: assert property (@(posedge clk) disable iff (!rst_n)
    entry_first |=> (psw_o[B_EP] && redirect_pc_o[31:16] == 16'hFFFF && redirect_o));
  // R4: secondary entry raises nesting-2 and uses the fixed vector
  a_r4_second_level: assert property (@(posedge clk) disable iff (!rst_n)
    entry_second |=> (psw_o[B_NP] && redirect_pc_o == VEC_SEC));
  // R7: every non-fatal entry masks interrupts and clears AE
  a_r7_entry_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_first || entry_second) |=> (psw_o[B_ID] && !psw_o[B_AE]));
  // R5: fatal stop is permanent and freezes the status word
  a_r5_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |=> (fatal_o && $stable(psw_o) && !redirect_o));
  // R2: an interrupt is never queued while masked or nested
  a_r2_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> !(psw_o[B_ID] || psw_o[B_EP] || psw_o[B_NP]));
  // R9: saved PCs are even
  a_r9_even_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (!eipc_o[0] && !fepc_o[0]));
  // R7: at most one kind of entry per cycle
  a_r7_one_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({entry_first, entry_second, entry_fatal}));
endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  irq_req = '0;
  logic        exc_valid = 1'b0;
  logic [15:0] exc_code = '0;
  logic [31:0] cur_pc = '0;
  logic        halted = 1'b0;
  logic        reti = 1'b0;
  logic        psw_wr = 1'b0;
  logic [31:0] psw_wd = '0;
  logic        redirect, wake, fatal, mem_wr;
  logic [31:0] rpc, psw, eipc, eipsw, fepc, fepsw, ecr, maddr, mdata;

  always #2 clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .exc_valid_i(exc_valid),
    .exc_code_i(exc_code), .cur_pc_i(cur_pc), .halted_i(halted), .reti_i(reti),
    .psw_wr_i(psw_wr), .psw_wr_data_i(psw_wd), .redirect_o(redirect),
    .redirect_pc_o(rpc), .psw_o(psw), .eipc_o(eipc), .eipsw_o(eipsw),
    .fepc_o(fepc), .fepsw_o(fepsw), .ecr_o(ecr), .wake_o(wake), .fatal_o(fatal),
    .mem_wr_o(mem_wr), .mem_addr_o(maddr), .mem_data_o(mdata)
  );

  int n_chk = 0;
  int n_err = 0;
  string tag = "R1";

  task automatic chk(input string t, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s got=%h exp=%h", t, what, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_psw, m_rpc, m_eipc, m_eipsw, m_fepc, m_fepsw, m_ecr;
  logic        m_redir, m_wake, m_fatal, m_pv, m_act;
  logic [15:0] m_code;
  int          m_idx;
  logic [31:0] m_w [3];
  bit          m_live = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_psw = 32'h8000; m_rpc = 32'hFFFFFFF0; m_ecr = 32'h0000FFF0;
      m_eipc = 0; m_eipsw = 0; m_fepc = 0; m_fepsw = 0;
      m_redir = 0; m_wake = 0; m_fatal = 0; m_pv = 0; m_act = 0; m_idx = 0; m_code = 0;
    end else if (m_fatal) begin
      if (m_act) begin
        if (m_idx == 2) m_act = 0; else m_idx = m_idx + 1;
      end
    end else begin
      logic [31:0] p0, np, sp;
      logic pv0, isint;
      p0 = m_psw; pv0 = m_pv;
      m_redir = 0; m_wake = 0;
      if (pv0) begin
        isint = (m_code[15:8] == 8'hFE);
        if (p0[15]) begin
          m_fatal = 1; m_act = 1; m_idx = 0;
          m_w[0] = 32'hFFFF0000 | {16'h0, m_code}; m_w[1] = p0; m_w[2] = cur_pc;
        end else begin
          sp = cur_pc + ((isint && halted) ? 32'd2 : 32'd0);
          sp[0] = 1'b0;
          np = p0;
          if (p0[14]) begin
            m_ecr[31:16] = m_code; m_fepc = sp; m_fepsw = p0; np[15] = 1; m_rpc = 32'hFFFFFFD0;
          end else begin
            m_ecr[15:0] = m_code; m_eipc = sp; m_eipsw = p0; np[14] = 1;
            m_rpc = 32'hFFFF0000 | {16'h0, m_code & 16'hFFF0};
            if (m_rpc == 32'hFFFFFF70) m_rpc = 32'hFFFFFF60;
          end
          if (isint) np[19:16] = m_code[7:4];
          np[13] = 0; np[12] = 1;
          m_psw = np & 32'h000FF3FF;
          m_redir = 1; m_wake = isint && halted;
        end
      end else if (reti) begin
        m_rpc = p0[15] ? m_fepc : m_eipc;
        m_psw = (p0[15] ? m_fepsw : m_eipsw) & 32'h000FF3FF;
        m_redir = 1;
      end else if (psw_wr) begin
        m_psw = psw_wd & 32'h000FF3FF;
      end
      if (exc_valid) begin
        m_pv = 1; m_code = exc_code;
      end else if (pv0) begin
        m_pv = 0;
      end else if (irq_req != 0 && !p0[12] && !p0[14] && !p0[15]) begin
        int lv;
        lv = 0;
        for (int i = 0; i < 5; i++) if (irq_req[i]) lv = i;
        m_pv = 1; m_code = 16'hFE00 | 16'(lv << 4);
      end
    end
  end

  always @(negedge clk) begin
    if (m_live) begin
      chk(tag, "redirect", {31'b0, redirect}, {31'b0, m_redir});
      chk(tag, "pc", rpc, m_rpc);
      chk(tag, "psw", psw, m_psw);
      chk(tag, "eipc", eipc, m_eipc);
      chk(tag, "eipsw", eipsw, m_eipsw);
      chk(tag, "fepc", fepc, m_fepc);
      chk(tag, "fepsw", fepsw, m_fepsw);
      chk(tag, "ecr", ecr, m_ecr);
      chk(tag, "wake", {31'b0, wake}, {31'b0, m_wake});
      chk(tag, "fatal", {31'b0, fatal}, {31'b0, m_fatal});
      chk(tag, "mem_wr", {31'b0, mem_wr}, {31'b0, m_act});
      if (m_act) begin
        chk(tag, "mem_addr", maddr, 32'(m_idx * 4));
        chk(tag, "mem_data", mdata, m_w[m_idx]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raise(input logic [15:0] c);
    exc_valid = 1; exc_code = c; step(1);
    exc_valid = 0; step(1);
  endtask

  task automatic ret();
    reti = 1; step(1); reti = 0; step(1);
  endtask

  task automatic wpsw(input logic [31:0] v);
    psw_wr = 1; psw_wd = v; step(1); psw_wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    m_live = 1;
    step(1);
    tag = "R1";
    chk("R1", "reset pc", rpc, 32'hFFFFFFF0);
    chk("R1", "reset ecr", ecr, 32'h0000FFF0);
    chk("R1", "reset psw", psw, 32'h00008000);

    tag = "R9";
    wpsw(32'hFFFFFFFF); step(1);
    chk("R9", "psw mask", psw, 32'h000FF3FF);
    wpsw(32'h00002005); step(1);

    tag = "R6";  // R2 level pick, R7 flags
    cur_pc = 32'h1001; irq_req = 5'b00110; step(2);
    chk("R2", "irq vector", rpc, 32'hFFFFFE20);
    chk("R6", "irq psw", psw, 32'h00025005);
    chk("R9", "eipc even", eipc, 32'h00001000);
    chk("R7", "redirect pulse", {31'b0, redirect}, 32'd1);
    tag = "R2";
    step(4);
    chk("R2", "masked irq no redirect", {31'b0, redirect}, 32'd0);
    irq_req = 0;

    tag = "R8";
    ret(); 
    chk("R8", "return pc", rpc, 32'h00001000);
    chk("R8", "return psw", psw, 32'h00002005);

    tag = "R3";
    cur_pc = 32'h2000; raise(16'hFF70); step(1);
    chk("R3", "redirected vector", rpc, 32'hFFFFFF60);
    chk("R3", "ecr low", ecr[15:0], 32'h0000FF70);
    chk("R3", "psw", psw, 32'h00005005);

    tag = "R4";
    irq_req = 5'b00001; cur_pc = 32'h3002; raise(16'hFF80); step(1);
    chk("R4", "second vector", rpc, 32'hFFFFFFD0);
    chk("R4", "ecr", ecr, 32'hFF80FF70);
    chk("R4", "fepsw", fepsw, 32'h00005005);
    irq_req = 0;

    tag = "R8";
    ret();
    chk("R8", "from secondary", rpc, 32'h00003002);
    chk("R8", "psw from secondary", psw, 32'h00005005);
    ret();
    chk("R8", "from primary", rpc, 32'h00002000);

    tag = "R10";
    cur_pc = 32'h4000;
    exc_valid = 1; exc_code = 16'hFF90; step(1);
    exc_code = 16'hFFA3; step(1);
    exc_valid = 0; step(2);
    chk("R10", "held code entered", ecr, 32'hFFA3FF90);
    chk("R10", "psw", psw, 32'h0000D005);
    ret(); ret();

    tag = "R11";
    irq_req = 5'b00001; raise(16'hFF60); irq_req = 0; step(1);
    chk("R11", "exception wins", ecr[15:0], 32'h0000FF60);
    step(3);
    ret();

    tag = "R6";
    halted = 1; cur_pc = 32'h5000; irq_req = 5'b10001; step(2);
    chk("R6", "halted save", eipc, 32'h00005002);
    chk("R6", "wake", {31'b0, wake}, 32'd1);
    chk("R6", "level field", psw, 32'h00045005);
    irq_req = 0; halted = 0; step(1);
    ret();

    tag = "R5";
    wpsw(32'h00008000); cur_pc = 32'h6000;
    raise(16'hFFA5);
    chk("R5", "fatal", {31'b0, fatal}, 32'd1);
    chk("R5", "dump addr0", maddr, 32'h0);
    chk("R5", "dump code", mdata, 32'hFFFFFFA5);
    step(1);
    chk("R5", "dump psw", mdata, 32'h00008000);
    step(1);
    chk("R5", "dump pc", maddr, 32'h8);
    chk("R5", "dump pc data", mdata, 32'h00006000);
    step(1);
    chk("R5", "dump done", {31'b0, mem_wr}, 32'd0);
    raise(16'hFF90); ret(); wpsw(32'h0); step(3);
    chk("R5", "frozen psw", psw, 32'h00008000);
    chk("R5", "still fatal", {31'b0, fatal}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule